// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block is the software-visible part of a system power-management controller. It holds three 16-bit registers: an event status register, an event enable register and a sleep-control register. All three sit in a 16-byte I/O window whose base address is a parameter. A host reaches them through a simple synchronous register bus. On one clock edge the bus presents a select strobe, a write flag, a dword-aligned byte address, four byte-lane strobes and 32 bits of write data. Read data comes back, registered, in the following cycle.

Software clears status flags by writing ones to them. A full 32-bit store to the first dword reloads status and enable together. When software writes a sleep command that asks for the soft-off state, the block sends a single-cycle power-off request to the platform.

Addresses are byte addresses and must be dword aligned. The first dword of the window, at offset 0, holds status in lanes 1:0 and enable in lanes 3:2. The second dword, at offset 4, holds control in lanes 1:0. The timer dword at offset 8 belongs to another block, so it reads as zero here.

Top module: `pm1_reg_block`

## Requirements
- R1: After reset, status reads 0x0000, enable reads 0x0000 and control reads 0x0001 (only bit 0, the interrupt-enable bit, is set). The power-off request is low.
- R2: A write at offset 0 with all four lane strobes set loads status from data bits 15:0 and enable from bits 31:16. A read at offset 0 returns enable in bits 31:16 and status in bits 15:0.
- R3: A partial write at offset 0 that strobes lane 0 clears status bit 0 (timer overflow) and status bit 5 (global) wherever the data holds a 1. All other status bits are left unchanged. A write to lane 1 alone leaves status unchanged.
- R4: A partial write at offset 0 replaces only the enable bytes whose lanes are strobed: lane 2 carries bits 7:0 and lane 3 carries bits 15:8.
- R5: A write at offset 4 replaces only the control bytes whose lanes are strobed: lane 0 carries bits 7:0 and lane 1 carries bits 15:8.
- R6: A write at offset 4 that strobes lane 1, with data bit 13 (sleep enable) at 1 and bits 12:10 (sleep type) at 3'b111, raises the power-off request for exactly the one cycle after the write edge. No other access raises it.
- R7: Read data is updated on the edge of a read access and holds its value at every other edge. Byte lanes that the read does not strobe return zero.
- R8: A misaligned address, an address outside the window, offsets 8 and 12, and lanes 3:2 at offset 4 all read as zero. Writes to any of them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Access strobe, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Byte address, dword aligned |
| io_be | input | 4 | Byte-lane strobes |
| io_wdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| io_rdata | output | 32 | Registered read data |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
The status register has no hardware event inputs, so its flags can only be set by the full-dword reload. Every clear-on-one case therefore starts with a 32-bit store that plants a known pattern, followed by narrow writes that aim ones at the clearable bits and at the bits that must stay put. The soft-off decode is hardest to isolate. The stimulus walks through near-miss commands: the right pattern with lane 1 unstrobed, sleep enable without the full type, and the full type with a wrong bit. It then checks that only the exact pattern produces the pulse, and that the pulse drops on the next cycle.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int REG_W      = 16;
  localparam int LANES      = 4;
  localparam int DW_EVENT   = 0;   // dword index of status/enable
  localparam int DW_CONTROL = 1;   // dword index of control
  localparam int ST_TMR_BIT = 0;
  localparam int ST_GBL_BIT = 5;
  localparam logic [REG_W-1:0] CTRL_RESET = 16'h0001;
  localparam logic [3:0] SOFT_OFF_CMD = 4'b1111; // {sleep enable, sleep type}

  // clear-on-one for the two clearable status flags
  function automatic logic [REG_W-1:0] status_after_w1c(
    input logic [REG_W-1:0] cur, input logic [7:0] lo, input logic lane0);
    logic [REG_W-1:0] kill;
    kill = '0;
    if (lane0) begin
      kill[ST_TMR_BIT] = lo[ST_TMR_BIT];
      kill[ST_GBL_BIT] = lo[ST_GBL_BIT];
    end
    return cur & ~kill;
  endfunction

  // byte merge for a 16-bit register under two lane strobes
  function automatic logic [REG_W-1:0] merge_lanes(
    input logic [REG_W-1:0] cur, input logic [REG_W-1:0] d, input logic [1:0] be);
    logic [REG_W-1:0] r;
    r = cur;
    if (be[0]) r[7:0]  = d[7:0];
    if (be[1]) r[15:8] = d[15:8];
    return r;
  endfunction

  // cmd = control bits 13:10
  function automatic logic is_soft_off(input logic [3:0] cmd);
    return cmd == SOFT_OFF_CMD;
  endfunction

  function automatic logic [31:0] lane_mask(input logic [LANES-1:0] be);
    logic [31:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/pm1_decode.sv
module pm1_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h1F40
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_event,
  output logic              wr_ctl,
  output logic              rd_any,
  output logic              rd_event,
  output logic              rd_ctl
);
  import pm1_pkg::*;
  logic in_win;
  logic [1:0] dw;

  assign in_win   = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
  assign dw       = addr[3:2];
  assign wr_event = sel && we  && in_win && (dw == 2'(DW_EVENT));
  assign wr_ctl   = sel && we  && in_win && (dw == 2'(DW_CONTROL));
  assign rd_any   = sel && !we;
  assign rd_event = rd_any && in_win && (dw == 2'(DW_EVENT));
  assign rd_ctl   = rd_any && in_win && (dw == 2'(DW_CONTROL));
endmodule

// File: rtl/pm1_regs.sv
module pm1_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_event,
  input  logic        wr_ctl,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [15:0] status_q,
  output logic [15:0] enable_q,
  output logic [15:0] control_q
);
  import pm1_pkg::*;
  logic full_dw;
  assign full_dw = (be == 4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= '0;
      enable_q  <= '0;
      control_q <= CTRL_RESET;
    end else begin
      if (wr_event) begin
        if (full_dw) begin
          status_q <= wdata[15:0];
          enable_q <= wdata[31:16];
        end else begin
          status_q <= status_after_w1c(status_q, wdata[7:0], be[0]);
          enable_q <= merge_lanes(enable_q, wdata[31:16], be[3:2]);
        end
      end
      if (wr_ctl) control_q <= merge_lanes(control_q, wdata[15:0], be[1:0]);
    end
  end
endmodule

// File: rtl/pm1_sleep_detect.sv
module pm1_sleep_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctl,
  input  logic       hi_lane,
  input  logic [3:0] cmd,
  output logic       sleep_hit,
  output logic       shutdown_req
);
  import pm1_pkg::*;
  assign sleep_hit = wr_ctl && hi_lane && is_soft_off(cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) shutdown_req <= 1'b0;
    else        shutdown_req <= sleep_hit;
  end
endmodule

// File: rtl/pm1_reg_block.sv
module pm1_reg_block #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h1F40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_sel,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [3:0]        io_be,
  input  logic [31:0]       io_wdata,
  output logic [31:0]       io_rdata,
  output logic              shutdown_req
);
  import pm1_pkg::*;
  logic wr_event, wr_ctl, rd_any, rd_event, rd_ctl, sleep_hit;
  logic [15:0] status_q, enable_q, control_q;
  logic [31:0] rd_word;

  pm1_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .sel(io_sel), .we(io_we), .addr(io_addr),
    .wr_event(wr_event), .wr_ctl(wr_ctl), .rd_any(rd_any),
    .rd_event(rd_event), .rd_ctl(rd_ctl));

  pm1_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_event(wr_event), .wr_ctl(wr_ctl),
    .be(io_be), .wdata(io_wdata),
    .status_q(status_q), .enable_q(enable_q), .control_q(control_q));

  pm1_sleep_detect u_sleep (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .hi_lane(io_be[1]),
    .cmd(io_wdata[13:10]), .sleep_hit(sleep_hit), .shutdown_req(shutdown_req));

  always_comb begin
    rd_word = '0;
    if (rd_event)    rd_word = {enable_q, status_q};
    else if (rd_ctl) rd_word = {16'h0000, control_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      io_rdata <= '0;
    else if (rd_any) io_rdata <= rd_word & lane_mask(io_be);
  end
endmodule

// File: rtl/pm1_reg_block_chk.sv
module pm1_reg_block_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'h1F40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_sel,
  input logic              io_we,
  input logic [ADDR_W-1:0] io_addr,
  input logic [3:0]        io_be,
  input logic [31:0]       io_wdata,
  input logic [31:0]       io_rdata,
  input logic              shutdown_req,
  input logic              sleep_hit,
  input logic              wr_ctl,
  input logic [15:0]       status_q,
  input logic [15:0]       enable_q,
  input logic [15:0]       control_q
);
  logic outside;
  assign outside = (io_addr[ADDR_W-1:4] != BASE[ADDR_W-1:4]) || (io_addr[1:0] != 2'b00);

  // R6
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(io_sel && io_we && io_be[1] && (io_addr == BASE + ADDR_W'(4))
                           && (io_wdata[13:10] == 4'hF)));
  // R6
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req && !sleep_hit) |=> !shutdown_req);
  // R3
  stat_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q)) != 16'h0) |->
      $past(io_sel && io_we && (io_addr == BASE) && (io_be == 4'hF)));
  // R8
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && io_we && outside) |=>
      ($stable(status_q) && $stable(enable_q) && $stable(control_q)));
  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_sel && !io_we) |=> $stable(io_rdata));
  // R7
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel && !io_we && !io_be[0]) |=> (io_rdata[7:0] == 8'h00));
  // R5
  ctl_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !io_be[1]) |=> $stable(control_q[15:8]));
endmodule

bind pm1_reg_block pm1_reg_block_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr),
  .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
  .shutdown_req(shutdown_req), .sleep_hit(sleep_hit), .wr_ctl(wr_ctl),
  .status_q(status_q), .enable_q(enable_q), .control_q(control_q));

// File: tb/pm1_reg_block_test.sv
`timescale 1ns/1ps
module pm1_reg_block_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic io_sel = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic shutdown_req;
  int total = 0, bad = 0;
  logic [31:0] held;

  pm1_reg_block uut (.clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_we(io_we),
    .io_addr(io_addr), .io_be(io_be), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .shutdown_req(shutdown_req));

  always #10 clk = ~clk;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_off;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 16'h1F40, 4'hF, 32'h0, 32'h0, 1'b0, 8'd1},                  // R1
    '{1'b0, 16'h1F44, 4'h3, 32'h0, 32'h1, 1'b0, 8'd1},                  // R1
    '{1'b1, 16'h1F40, 4'hF, 32'hA5A58D31, 32'h0, 1'b0, 8'd2},           // R2
    '{1'b0, 16'h1F40, 4'hF, 32'h0, 32'hA5A58D31, 1'b0, 8'd2},           // R2
    '{1'b1, 16'h1F40, 4'h1, 32'h00000021, 32'h0, 1'b0, 8'd3},           // R3
    '{1'b0, 16'h1F40, 4'h3, 32'h0, 32'h00008D10, 1'b0, 8'd3},           // R3
    '{1'b1, 16'h1F40, 4'h2, 32'h0000FF00, 32'h0, 1'b0, 8'd3},           // R3
    '{1'b0, 16'h1F40, 4'hF, 32'h0, 32'hA5A58D10, 1'b0, 8'd3},           // R3
    '{1'b1, 16'h1F40, 4'h4, 32'h003C0000, 32'h0, 1'b0, 8'd4},           // R4
    '{1'b0, 16'h1F40, 4'hC, 32'h0, 32'hA53C0000, 1'b0, 8'd4},           // R4
    '{1'b1, 16'h1F40, 4'h8, 32'h5A000000, 32'h0, 1'b0, 8'd4},           // R4
    '{1'b0, 16'h1F40, 4'hF, 32'h0, 32'h5A3C8D10, 1'b0, 8'd4},           // R4
    '{1'b1, 16'h1F44, 4'h1, 32'h000000F5, 32'h0, 1'b0, 8'd5},           // R5
    '{1'b1, 16'h1F44, 4'h2, 32'h00002000, 32'h0, 1'b0, 8'd5},           // R5
    '{1'b0, 16'h1F44, 4'h3, 32'h0, 32'h000020F5, 1'b0, 8'd5},           // R5
    '{1'b1, 16'h1F48, 4'hF, 32'hFFFFFFFF, 32'h0, 1'b0, 8'd8},           // R8
    '{1'b0, 16'h1F48, 4'hF, 32'h0, 32'h0, 1'b0, 8'd8},                  // R8
    '{1'b1, 16'h1F44, 4'hC, 32'hFFFF0000, 32'h0, 1'b0, 8'd8},           // R8
    '{1'b0, 16'h1F44, 4'hF, 32'h0, 32'h000020F5, 1'b0, 8'd8},           // R8
    '{1'b1, 16'h1F50, 4'hF, 32'h0, 32'h0, 1'b0, 8'd8},                  // R8
    '{1'b1, 16'h1F42, 4'hF, 32'h0, 32'h0, 1'b0, 8'd8},                  // R8
    '{1'b0, 16'h1F40, 4'hF, 32'h0, 32'h5A3C8D10, 1'b0, 8'd8},           // R8
    '{1'b0, 16'h1F42, 4'hF, 32'h0, 32'h0, 1'b0, 8'd8},                  // R8
    '{1'b1, 16'h1F44, 4'h1, 32'h00003C00, 32'h0, 1'b0, 8'd6},           // R6
    '{1'b1, 16'h1F44, 4'h3, 32'h00000C01, 32'h0, 1'b0, 8'd6},           // R6
    '{1'b1, 16'h1F44, 4'h3, 32'h00003801, 32'h0, 1'b0, 8'd6},           // R6
    '{1'b1, 16'h1F44, 4'h3, 32'h00003C01, 32'h0, 1'b1, 8'd6},           // R6
    '{1'b0, 16'h1F44, 4'h1, 32'h0, 32'h00000001, 1'b0, 8'd7}            // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] wd);
    @(negedge clk);
    io_sel = 1'b1; io_we = we; io_addr = a; io_be = be; io_wdata = wd;
    @(negedge clk);
    io_sel = 1'b0; io_we = 1'b0;
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 off after reset", {31'h0, shutdown_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, VEC[i].addr, VEC[i].be, VEC[i].wd);
      if (!VEC[i].we) check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), io_rdata, VEC[i].exp_rd);
      check($sformatf("R%0d vec%0d off", VEC[i].req, i), {31'h0, shutdown_req}, {31'h0, VEC[i].exp_off});
    end
    // R6 pulse width: gone one cycle later
    @(negedge clk);
    check("R6 pulse one cycle", {31'h0, shutdown_req}, 32'h0);

    // R6 byte write to control high lane also triggers
    access(1'b1, 16'h1F44, 4'h2, 32'h00003C00);
    check("R6 high-byte trigger", {31'h0, shutdown_req}, 32'h1);
    @(negedge clk);
    check("R6 high-byte pulse drop", {31'h0, shutdown_req}, 32'h0);

    // R3 word write clears bit 0 only; bit 5 untouched when written 0
    access(1'b1, 16'h1F40, 4'hF, 32'h00008421);
    access(1'b1, 16'h1F40, 4'h3, 32'h0000FFC1);
    access(1'b0, 16'h1F40, 4'h3, 32'h0);
    check("R3 word clear", io_rdata, 32'h00008420);

    // R7 read data holds across a write and idle cycles
    held = io_rdata;
    access(1'b1, 16'h1F40, 4'h4, 32'h00770000);
    repeat (2) @(negedge clk);
    check("R7 hold", io_rdata, held);

    // R1 reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    access(1'b0, 16'h1F40, 4'hF, 32'h0);
    check("R1 event after reset", io_rdata, 32'h0);
    access(1'b0, 16'h1F44, 4'hF, 32'h0);
    check("R1 control after reset", io_rdata, 32'h00000001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule